// File: doc/BRIEF.md
# Peer Doorbell Register Window

This block is the small register window that a host uses to control interrupts of a device whose memory is shared between several peers. It decodes a 256-byte address range into four 32-bit words: an interrupt enable, an interrupt flag, a read-only word giving the device's own identity, and a write-only doorbell. A write to the doorbell names a target peer and an interrupt vector. When the request can be delivered, the block sends it as a one-cycle pulse on a routing output toward the peer fabric. Otherwise it drops the write without any trace.

Interrupts that arrive from peers set the local flag. When no message-signalled interrupt capability is present, the block drives a level interrupt line from the flag and the enable. Configuration inputs supply the local identity, whether interrupts are configured at all, whether interrupt setup has finished, and how many vectors each peer has connected.

The doorbell path is a two-state machine. In `BELL_IDLE` no pulse is driven. In `BELL_FIRE` the routing pulse is driven for the payload captured at the last edge. Two transitions lead into `BELL_FIRE`: ACCEPT from `BELL_IDLE`, and ACCEPT from `BELL_FIRE`, which covers doorbells written back to back. Two transitions lead into `BELL_IDLE`: QUIET from `BELL_IDLE` and QUIET from `BELL_FIRE`. A cycle is ACCEPT when it carries a deliverable doorbell write, and QUIET when it does not.

Top module: `peer_bell_regs`

## Requirements
- R1: After reset the enable and flag bits read 0, `intx` is low and `ring_valid` is low.
- R2: The word at byte offset 0 is the interrupt enable. Bit 0 is written from `wr_data[0]` and reads back. Bits 31:1 always read 0.
- R3: The word at offset 4 holds the interrupt flag in bit 0, and bits 31:1 read 0.
    - A `peer_irq_in` pulse sets the flag.
    - A write at offset 4 loads the flag from `wr_data[0]`.
    - A read at offset 4 returns the current value and clears the flag at that edge.
    - An incoming `peer_irq_in` in the same cycle overrides the clear or the written 0.
- R4: `intx` is high exactly when the flag and the enable are both 1 and `msix_present` is 0.
- R5: The word at offset 8 reads `local_id` zero-extended to 32 bits while `irq_cfg_en` is 1, and reads 0 otherwise. Writes to it change nothing.
- R6: A write at offset 12 is a doorbell: the target peer is `wr_data[31:16]` and the vector is `wr_data[15:0]`. When the doorbell is accepted, `ring_valid` is high in the following cycle only, with `ring_peer` and `ring_vec` carrying the written values.
- R7: A doorbell is dropped, leaving `ring_valid` low, while `irq_cfg_en` is 0 or `setup_done` is 0.
- R8: A doorbell is dropped in any of these cases:
    - the target peer is not below `NUM_PEERS`;
    - the target's connected-vector count is 0, which marks the peer as not connected;
    - the vector is not below that count.
  The count of peer i is `peer_vec_cnt[i*CNT_W +: CNT_W]`.
- R9: Reads at offset 12 and at every offset from 16 to 255 return 0. Writes at offsets 16 to 255 change neither the enable nor the flag.
- R10: Doorbells accepted in consecutive cycles give a pulse in each of the consecutive following cycles, and each pulse carries its own peer and vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Byte address within the window (bits 1:0 ignored) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; a read of the flag word clears the flag |
| rd_data | output | 32 | Combinational read data for `addr` |
| local_id | input | 16 | This device's peer identity |
| irq_cfg_en | input | 1 | Interrupts are configured |
| setup_done | input | 1 | Interrupt setup has completed |
| peer_vec_cnt | input | NUM_PEERS*CNT_W | Connected-vector count per peer, peer 0 in the low field |
| msix_present | input | 1 | Message-signalled interrupts in use; masks `intx` |
| peer_irq_in | input | 1 | Pulse: a peer interrupted this device |
| intx | output | 1 | Level interrupt line |
| ring_valid | output | 1 | One-cycle pulse for an accepted doorbell |
| ring_peer | output | 16 | Target peer of the pulse |
| ring_vec | output | 16 | Vector of the pulse |

## Verification
The doorbell is driven with every combination of the two configuration enables, every target peer from 0 to 5 and every vector from 0 to 7. The peer counts are 2, 0, 5 and 1, so the sweep separates the following cases:
- peers that do not exist;
- a peer that exists but is not connected;
- vectors that fall just inside or just outside a peer's count.

Further doorbells use a large vector and a large peer number, to catch comparisons made on truncated fields. Two writes in successive cycles show that the state machine re-enters its firing state. Separate sweeps do the following:
- cover all eight combinations of enable, flag and capability for the level line;
- walk every reserved offset, for reads and for writes;
- collide an incoming peer interrupt with a clearing read, to show that the incoming interrupt wins.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

    localparam int unsigned PEER_W = 16;
    localparam int unsigned VEC_W  = 16;
    localparam int unsigned DW     = PEER_W + VEC_W;

    // word index (byte offset / 4) of each live register
    localparam int unsigned WIDX_MASK = 0;
    localparam int unsigned WIDX_STAT = 1;
    localparam int unsigned WIDX_POS  = 2;
    localparam int unsigned WIDX_BELL = 3;

    typedef enum logic [2:0] {
        SEL_MASK,
        SEL_STAT,
        SEL_POS,
        SEL_BELL,
        SEL_NONE
    } reg_sel_e;

    typedef enum logic [0:0] {
        BELL_IDLE,
        BELL_FIRE
    } bell_state_e;

endpackage

// File: rtl/pbr_decode.sv
module pbr_decode
    import pbr_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input  logic [AW-1:0] addr,
    output reg_sel_e      sel
);
    localparam int unsigned WI_W = AW - 2;

    logic [WI_W-1:0] widx;
    assign widx = addr[AW-1:2];

    always_comb begin
        if (widx == WI_W'(WIDX_MASK))      sel = SEL_MASK;
        else if (widx == WI_W'(WIDX_STAT)) sel = SEL_STAT;
        else if (widx == WI_W'(WIDX_POS))  sel = SEL_POS;
        else if (widx == WI_W'(WIDX_BELL)) sel = SEL_BELL;
        else                               sel = SEL_NONE;
    end
endmodule

// File: rtl/pbr_flags.sv
module pbr_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic mask_wr,
    input  logic stat_wr,
    input  logic stat_rd,
    input  logic wbit,
    input  logic irq_in,
    input  logic msix_present,
    output logic mask_q,
    output logic stat_q,
    output logic intx
);
    logic stat_d;

    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= 1'b0;
        else if (mask_wr) mask_q <= wbit;
    end

    // an arriving peer interrupt beats both a clearing read and a write of 0
    always_comb begin
        stat_d = stat_q;
        if (stat_rd) stat_d = 1'b0;
        if (stat_wr) stat_d = wbit;
        if (irq_in)  stat_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= 1'b0;
        else        stat_q <= stat_d;
    end

    assign intx = stat_q & mask_q & ~msix_present;
endmodule

// File: rtl/pbr_bell.sv
module pbr_bell
    import pbr_pkg::*;
#(
    parameter int unsigned NUM_PEERS = 4,
    parameter int unsigned CNT_W     = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bell_wr,
    input  logic [DW-1:0]              wdata,
    input  logic                       irq_cfg_en,
    input  logic                       setup_done,
    input  logic [NUM_PEERS*CNT_W-1:0] peer_vec_cnt,
    output logic                       ring_valid,
    output logic [PEER_W-1:0]          ring_peer,
    output logic [VEC_W-1:0]           ring_vec
);
    logic [CNT_W-1:0]  cnt_arr [NUM_PEERS];
    logic [PEER_W-1:0] req_peer;
    logic [VEC_W-1:0]  req_vec;
    logic [CNT_W-1:0]  cnt_sel;
    logic              vec_ok;
    logic              accept;
    bell_state_e       state_q, state_d;
    logic [PEER_W-1:0] peer_q;
    logic [VEC_W-1:0]  vec_q;

    for (genvar g = 0; g < NUM_PEERS; g++) begin : g_cnt
        assign cnt_arr[g] = peer_vec_cnt[g*CNT_W +: CNT_W];
    end

    assign req_peer = wdata[DW-1:VEC_W];
    assign req_vec  = wdata[VEC_W-1:0];

    // peer numbers outside the table select a count of 0, i.e. not connected
    always_comb begin
        cnt_sel = '0;
        for (int i = 0; i < NUM_PEERS; i++) begin
            if (req_peer == PEER_W'(i)) cnt_sel = cnt_arr[i];
        end
    end

    assign vec_ok = ({{(VEC_W+1){1'b0}}, req_vec} < (VEC_W+1+CNT_W)'(cnt_sel));
    assign accept = bell_wr & irq_cfg_en & setup_done & vec_ok;

    // next-state process
    always_comb begin
        unique case (state_q)
            BELL_IDLE: state_d = accept ? BELL_FIRE : BELL_IDLE;
            BELL_FIRE: state_d = accept ? BELL_FIRE : BELL_IDLE;
            default:   state_d = BELL_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BELL_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peer_q <= '0;
            vec_q  <= '0;
        end else if (accept) begin
            peer_q <= req_peer;
            vec_q  <= req_vec;
        end
    end

    // output process
    always_comb begin
        unique case (state_q)
            BELL_FIRE: ring_valid = 1'b1;
            default:   ring_valid = 1'b0;
        endcase
    end

    assign ring_peer = peer_q;
    assign ring_vec  = vec_q;
endmodule

// File: rtl/peer_bell_regs.sv
module peer_bell_regs
    import pbr_pkg::*;
#(
    parameter int unsigned AW        = 8,
    parameter int unsigned NUM_PEERS = 4,
    parameter int unsigned CNT_W     = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [AW-1:0]              addr,
    input  logic                       wr_en,
    input  logic [31:0]                wr_data,
    input  logic                       rd_en,
    output logic [31:0]                rd_data,
    input  logic [15:0]                local_id,
    input  logic                       irq_cfg_en,
    input  logic                       setup_done,
    input  logic [NUM_PEERS*CNT_W-1:0] peer_vec_cnt,
    input  logic                       msix_present,
    input  logic                       peer_irq_in,
    output logic                       intx,
    output logic                       ring_valid,
    output logic [15:0]                ring_peer,
    output logic [15:0]                ring_vec
);
    reg_sel_e sel;
    logic     mask_q;
    logic     stat_q;

    pbr_decode #(.AW(AW)) u_decode (
        .addr (addr),
        .sel  (sel)
    );

    pbr_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .mask_wr      (wr_en && sel == SEL_MASK),
        .stat_wr      (wr_en && sel == SEL_STAT),
        .stat_rd      (rd_en && sel == SEL_STAT),
        .wbit         (wr_data[0]),
        .irq_in       (peer_irq_in),
        .msix_present (msix_present),
        .mask_q       (mask_q),
        .stat_q       (stat_q),
        .intx         (intx)
    );

    pbr_bell #(.NUM_PEERS(NUM_PEERS), .CNT_W(CNT_W)) u_bell (
        .clk          (clk),
        .rst_n        (rst_n),
        .bell_wr      (wr_en && sel == SEL_BELL),
        .wdata        (wr_data),
        .irq_cfg_en   (irq_cfg_en),
        .setup_done   (setup_done),
        .peer_vec_cnt (peer_vec_cnt),
        .ring_valid   (ring_valid),
        .ring_peer    (ring_peer),
        .ring_vec     (ring_vec)
    );

    always_comb begin
        unique case (sel)
            SEL_MASK: rd_data = {31'd0, mask_q};
            SEL_STAT: rd_data = {31'd0, stat_q};
            SEL_POS:  rd_data = irq_cfg_en ? {16'd0, local_id} : 32'd0;
            default:  rd_data = 32'd0;
        endcase
    end
endmodule

// File: rtl/peer_bell_regs_chk.sv
module peer_bell_regs_chk #(
    parameter int unsigned AW        = 8,
    parameter int unsigned NUM_PEERS = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          wr_en,
    input logic          rd_en,
    input logic [31:0]   rd_data,
    input logic          irq_cfg_en,
    input logic          setup_done,
    input logic          msix_present,
    input logic          peer_irq_in,
    input logic          intx,
    input logic          ring_valid,
    input logic [15:0]   ring_peer,
    input logic          stat_q
);
    localparam int unsigned WI_W = AW - 2;

    logic [WI_W-1:0] widx;
    assign widx = addr[AW-1:2];

    // R4: the capability input always silences the level line
    a_r4_msix_masks: assert property (@(posedge clk) disable iff (!rst_n)
        msix_present |-> !intx);

    // R3: an incoming peer interrupt always leaves the flag set
    a_r3_irq_sets: assert property (@(posedge clk) disable iff (!rst_n)
        peer_irq_in |=> stat_q);

    // R3: a clearing read with no incoming interrupt and no write leaves the flag clear
    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !peer_irq_in && widx == WI_W'(1)) |=> !stat_q);

    // R6 and R7: every pulse follows a doorbell write made while enabled and set up
    a_r6_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
        ring_valid |-> $past(wr_en && widx == WI_W'(3) && irq_cfg_en && setup_done));

    // R8: a pulse never names a peer outside the table
    a_r8_peer_range: assert property (@(posedge clk) disable iff (!rst_n)
        ring_valid |-> (ring_peer < 16'(NUM_PEERS)));

    // R5: the identity word reads zero while interrupts are unconfigured
    a_r5_pos_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (widx == WI_W'(2) && !irq_cfg_en) |-> rd_data == 32'd0);

    // R9: reserved words read zero
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (widx > WI_W'(2)) |-> rd_data == 32'd0);
endmodule

bind peer_bell_regs peer_bell_regs_chk #(.AW(AW), .NUM_PEERS(NUM_PEERS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr         (addr),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .rd_data      (rd_data),
    .irq_cfg_en   (irq_cfg_en),
    .setup_done   (setup_done),
    .msix_present (msix_present),
    .peer_irq_in  (peer_irq_in),
    .intx         (intx),
    .ring_valid   (ring_valid),
    .ring_peer    (ring_peer),
    .stat_q       (stat_q)
);

// File: tb/peer_bell_regs_bench.sv
module peer_bell_regs_bench;
    localparam int AW = 8;
    localparam int NP = 4;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic          rd_en = 1'b0;
    logic [31:0]   rd_data;
    logic [15:0]   local_id = 16'hBEEF;
    logic          irq_cfg_en = 1'b0;
    logic          setup_done = 1'b0;
    logic [NP*CW-1:0] peer_vec_cnt = {4'd1, 4'd5, 4'd0, 4'd2};
    logic          msix_present = 1'b0;
    logic          peer_irq_in = 1'b0;
    logic          intx;
    logic          ring_valid;
    logic [15:0]   ring_peer;
    logic [15:0]   ring_vec;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    peer_bell_regs #(.AW(AW), .NUM_PEERS(NP), .CNT_W(CW)) u_peer_bell_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .local_id(local_id),
        .irq_cfg_en(irq_cfg_en), .setup_done(setup_done),
        .peer_vec_cnt(peer_vec_cnt), .msix_present(msix_present),
        .peer_irq_in(peer_irq_in), .intx(intx), .ring_valid(ring_valid),
        .ring_peer(ring_peer), .ring_vec(ring_vec)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int off, input logic [31:0] d);
        @(negedge clk);
        addr = AW'(off); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int off, output logic [31:0] d);
        @(negedge clk);
        addr = AW'(off); rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic int cnt_of(input int p);
        case (p)
            0: return 2;
            1: return 0;
            2: return 5;
            3: return 1;
            default: return 0;
        endcase
    endfunction

    // one doorbell, then the pulse cycle, then the cycle after it
    task automatic bell(input string req, input int p, input int v);
        bit exp;
        exp = irq_cfg_en && setup_done && p < NP && v < cnt_of(p);
        @(negedge clk);
        addr = AW'(12); wr_data = {16'(p), 16'(v)}; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk(req, {31'd0, ring_valid}, {31'd0, exp});
        if (exp) chk(req, {ring_peer, ring_vec}, {16'(p), 16'(v)});
        @(negedge clk);
        chk(req, {31'd0, ring_valid}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, d); chk("R1 mask", d, 0);
        rd(4, d); chk("R1 stat", d, 0);
        chk("R1 intx", {31'd0, intx}, 0);
        chk("R1 ring", {31'd0, ring_valid}, 0);

        // R2 enable word
        wr(0, 32'hFFFF_FFFF); rd(0, d); chk("R2 set", d, 1);
        wr(0, 32'hFFFF_FFFE); rd(0, d); chk("R2 clr", d, 0);

        // R3 flag
        @(negedge clk); peer_irq_in = 1'b1; @(negedge clk); peer_irq_in = 1'b0;
        rd(4, d); chk("R3 set by irq", d, 1);
        rd(4, d); chk("R3 clear on read", d, 0);
        wr(4, 32'hFFFF_FFFF); rd(4, d); chk("R3 write 1", d, 1);
        rd(4, d); chk("R3 cleared after read", d, 0);
        @(negedge clk); addr = AW'(4); rd_en = 1'b1; peer_irq_in = 1'b1;
        #1 chk("R3 collide old value", rd_data, 0);
        @(negedge clk); rd_en = 1'b0; peer_irq_in = 1'b0;
        rd(4, d); chk("R3 irq beats clear", d, 1);
        @(negedge clk); addr = AW'(4); wr_data = 0; wr_en = 1'b1; peer_irq_in = 1'b1;
        @(negedge clk); wr_en = 1'b0; peer_irq_in = 1'b0;
        rd(4, d); chk("R3 irq beats write 0", d, 1);

        // R4 level line sweep
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 2; s++)
                for (int x = 0; x < 2; x++) begin
                    wr(0, 32'(m)); wr(4, 32'(s));
                    msix_present = x[0];
                    #1 chk("R4 intx", {31'd0, intx}, 32'((m & s) & (x ^ 1)));
                end
        msix_present = 1'b0;
        wr(0, 0); wr(4, 0);

        // R5 identity word
        irq_cfg_en = 1'b0; rd(8, d); chk("R5 unconfigured", d, 0);
        irq_cfg_en = 1'b1; rd(8, d); chk("R5 id", d, 32'h0000_BEEF);
        wr(8, 32'h1234_5678); rd(8, d); chk("R5 write ignored", d, 32'h0000_BEEF);

        // R9 reserved space
        rd(12, d); chk("R9 bell reads 0", d, 0);
        for (int o = 16; o < 256; o += 4) begin
            rd(o, d); chk("R9 reserved read", d, 0);
            wr(o, 32'hFFFF_FFFF);
        end
        rd(0, d); chk("R9 mask untouched", d, 0);
        rd(4, d); chk("R9 stat untouched", d, 0);

        // R6 R7 R8 doorbell sweep
        for (int c = 0; c < 4; c++) begin
            irq_cfg_en = c[0]; setup_done = c[1];
            for (int p = 0; p < 6; p++)
                for (int v = 0; v < 8; v++)
                    bell((c == 3) ? "R6 R8 sweep" : "R7 sweep", p, v);
        end
        irq_cfg_en = 1'b1; setup_done = 1'b1;
        bell("R8 big vector", 2, 16'h0100);
        bell("R8 big peer", 16'h8000, 0);
        bell("R6 top vector", 2, 4);

        // R10 back to back
        @(negedge clk); addr = AW'(12); wr_data = {16'd2, 16'd3}; wr_en = 1'b1;
        @(negedge clk); wr_data = {16'd0, 16'd1};
        chk("R10 first pulse", {ring_valid, 15'd0, ring_peer}, {1'b1, 15'd0, 16'd2});
        chk("R10 first vec", {16'd0, ring_vec}, 3);
        @(negedge clk); wr_en = 1'b0;
        chk("R10 second pulse", {ring_valid, 15'd0, ring_peer}, {1'b1, 15'd0, 16'd0});
        chk("R10 second vec", {16'd0, ring_vec}, 1);
        @(negedge clk);
        chk("R10 idle after", {31'd0, ring_valid}, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule